// File: doc/BRIEF.md
# Counter Input Capture Unit

This block snapshots the value of a free-running 12-bit PWM counter into a capture register. The counter is an input. A capture can come from either of two sources. The first is a rising edge on the selected hardware event line, which is either an external pin or an analog comparator output. The second is a software trigger issued through the control register. Hardware captures are gated by an enable bit. Software captures are always honoured.

A CPU reaches the block over a byte-wide register bus. The 12-bit capture value is wider than the bus, so both bytes pass through a single 8-bit high-byte holding register. When the CPU reads the low byte, the high part is frozen in that holding register. A following high-byte read returns the frozen value, so a capture that lands between the two reads cannot tear the value. The write path works the other way round: the high byte is staged first, and the low-byte write commits all 12 bits at once.

The trigger bit in the control register has two uses. Writing 1 to it forces a capture. Reading it tells software which source caused the most recent capture. Every capture also raises a one-cycle done strobe.

Top module: `ctr_capture_unit`

## Requirements
- R1: After reset, the control register, both capture bytes, the holding register and `cap_done_o` all read 0.
- R2: Writing the control register (address 0) with bit 7 set loads the counter value present in that cycle into the capture register. `cap_done_o` is 1 for exactly the cycle after that clock edge. This happens regardless of the enable bit.
- R3: Bit 7 of the control register reads 1 when the latest capture came from the software trigger. It reads 0 when the latest capture came from the hardware event.
- R4: A rising edge on the selected event line passes through a two-flop synchronizer and an edge detector. The capture then fires on the fourth clock edge after the line goes high, and it stores the counter value present just before that edge. `cap_done_o` goes high after that edge.
- R5: Only a rising edge captures. Holding the line high, or letting it fall, causes no further capture.
- R6: Control bit 1 selects the event source: 0 selects the pin and 1 selects the comparator. The unselected line has no effect.
- R7: While control bit 0 (enable) is 0, hardware edges cause no capture and the capture register keeps its value.
- R8: When a software trigger and a hardware capture fall on the same edge, exactly one capture is taken and bit 7 reads 1.
- R9: Reading address 1 returns capture bits 7:0 and copies capture bits 11:8 into the holding register in the same cycle. Reading address 2 returns the holding register, zero-extended.
- R10: Writing address 2 loads the holding register and leaves the capture register unchanged. Writing address 1 then sets the capture register to {holding[3:0], written byte}.
- R11: If a capture and a CPU write to address 1 fall on the same edge, the capture wins and the written value is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 12 | Free-running counter value |
| pin_evt_i | input | 1 | External capture event line (asynchronous) |
| cmp_evt_i | input | 1 | Comparator capture event line (asynchronous) |
| bus_addr_i | input | 2 | Register address: 0 control, 1 capture low, 2 capture high |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the current address (combinational) |
| cap_done_o | output | 1 | One-cycle pulse after each capture |

## Verification
The following properties are checked by assertions on every cycle:
- Every capture loads the counter value that was present when it fired.
- The source flag follows the source that fired, with software winning a collision.
- The done strobe mirrors the firing.
- The capture register holds its value unless a capture or a commit occurs.
- The hardware path never fires on two cycles in a row.
- Each read or write of the holding register leaves the expected value in it.

Other behaviours can only be shown by the bench's scenarios:
- The exact four-edge latency from the asynchronous line to the capture.
- The suppression of disabled or unselected sources.
- The tear-free read across an intervening capture.
- Write-then-commit staging.
- The outcome of a capture colliding with a CPU commit.

// File: rtl/ccap_pkg.sv
package ccap_pkg;

   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_CAP_LO = 2'd1,
      REG_CAP_HI = 2'd2,
      REG_NONE   = 2'd3
   } reg_sel_e;

   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_SEL_BIT = 1;
   localparam int N_EVT_SRC    = 2;

endpackage

// File: rtl/ccap_evt_front.sv
module ccap_evt_front #(
   parameter int SYNC_STAGES = 2,
   parameter int N_SRC       = 2,
   localparam int SEL_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             en_i,
   output logic             hw_fire_o
);

   logic [N_SRC-1:0] synced;
   logic             lvl;
   logic             lvl_d;
   logic             rise;
   logic             rise_q;

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_STAGES-2:0], src_i[s]};
      end
      assign synced[s] = chain[SYNC_STAGES-1];
   end

   assign lvl  = synced[sel_i];
   assign rise = lvl & ~lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d  <= 1'b0;
         rise_q <= 1'b0;
      end else begin
         lvl_d  <= lvl;
         rise_q <= rise;
      end
   end

   assign hw_fire_o = rise_q & en_i;

   // R5: one edge can only fire on a single cycle
   p_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hw_fire_o |=> !hw_fire_o);

endmodule

// File: rtl/ccap_capture_reg.sv
module ccap_capture_reg #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             sw_fire_i,
   input  logic             hw_fire_i,
   input  logic             commit_i,
   input  logic [CNT_W-1:0] commit_val_i,
   output logic [CNT_W-1:0] cap_o,
   output logic             src_sw_o,
   output logic             done_o
);

   logic fire;
   assign fire = sw_fire_i | hw_fire_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_o    <= '0;
         src_sw_o <= 1'b0;
         done_o   <= 1'b0;
      end else begin
         done_o <= fire;
         if (fire) begin
            cap_o    <= cnt_i;
            src_sw_o <= sw_fire_i;
         end else if (commit_i) begin
            cap_o <= commit_val_i;
         end
      end
   end

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_fire_i || hw_fire_i) |=> cap_o == $past(cnt_i));

   p_src_sw_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_fire_i |=> src_sw_o);

   p_src_hw_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_fire_i && !sw_fire_i) |=> !src_sw_o);

   p_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_fire_i || hw_fire_i) |=> done_o);

   p_no_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_fire_i || hw_fire_i) |=> !done_o);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_fire_i || hw_fire_i || commit_i) |=> $stable(cap_o));

endmodule

// File: rtl/ccap_bus_if.sv
module ccap_bus_if
   import ccap_pkg::*;
#(
   parameter int CNT_W  = 12,
   parameter int DATA_W = 8,
   localparam int HI_W  = CNT_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic [CNT_W-1:0]  cap_i,
   input  logic              src_sw_i,
   output logic              en_o,
   output logic              sel_o,
   output logic              sw_fire_o,
   output logic              commit_o,
   output logic [CNT_W-1:0]  commit_val_o
);

   reg_sel_e          rsel;
   logic [DATA_W-1:0] hold_q;
   logic              wr_ctrl, wr_lo, wr_hi, rd_lo;

   assign rsel    = reg_sel_e'(bus_addr_i);
   assign wr_ctrl = bus_wr_i && (rsel == REG_CTRL);
   assign wr_lo   = bus_wr_i && (rsel == REG_CAP_LO);
   assign wr_hi   = bus_wr_i && (rsel == REG_CAP_HI);
   assign rd_lo   = bus_rd_i && !bus_wr_i && (rsel == REG_CAP_LO);

   assign sw_fire_o    = wr_ctrl && bus_wdata_i[DATA_W-1];
   assign commit_o     = wr_lo;
   assign commit_val_o = {hold_q[HI_W-1:0], bus_wdata_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o   <= 1'b0;
         sel_o  <= 1'b0;
         hold_q <= '0;
      end else begin
         if (wr_ctrl) begin
            en_o  <= bus_wdata_i[CTRL_EN_BIT];
            sel_o <= bus_wdata_i[CTRL_SEL_BIT];
         end
         if (wr_hi)      hold_q <= bus_wdata_i;
         else if (rd_lo) hold_q <= DATA_W'(cap_i[CNT_W-1:DATA_W]);
      end
   end

   always_comb begin
      bus_rdata_o = '0;
      unique case (rsel)
         REG_CTRL: begin
            bus_rdata_o[DATA_W-1]     = src_sw_i;
            bus_rdata_o[CTRL_SEL_BIT] = sel_o;
            bus_rdata_o[CTRL_EN_BIT]  = en_o;
         end
         REG_CAP_LO: bus_rdata_o = cap_i[DATA_W-1:0];
         REG_CAP_HI: bus_rdata_o = hold_q;
         REG_NONE:   bus_rdata_o = '0;
      endcase
   end

   p_hold_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo |=> hold_q == $past(DATA_W'(cap_i[CNT_W-1:DATA_W])));

   p_hold_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> hold_q == $past(bus_wdata_i));

endmodule

// File: rtl/ctr_capture_unit.sv
module ctr_capture_unit
   import ccap_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              pin_evt_i,
   input  logic              cmp_evt_i,
   input  logic [1:0]        bus_addr_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              cap_done_o
);

   if (CNT_W <= DATA_W || CNT_W > 2 * DATA_W) begin : g_bad_width
      $error("CNT_W must exceed DATA_W and fit in two bus bytes");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DATA_W < 3) begin : g_bad_data
      $error("DATA_W too narrow for the control fields");
   end

   logic             en, sel, sw_fire, hw_fire, commit, src_sw;
   logic [CNT_W-1:0] cap, commit_val;

   ccap_evt_front #(
      .SYNC_STAGES (SYNC_STAGES),
      .N_SRC       (N_EVT_SRC)
   ) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     ({cmp_evt_i, pin_evt_i}),
      .sel_i     (sel),
      .en_i      (en),
      .hw_fire_o (hw_fire)
   );

   ccap_capture_reg #(
      .CNT_W (CNT_W)
   ) u_cap (
      .clk          (clk),
      .rst_n        (rst_n),
      .cnt_i        (cnt_i),
      .sw_fire_i    (sw_fire),
      .hw_fire_i    (hw_fire),
      .commit_i     (commit),
      .commit_val_i (commit_val),
      .cap_o        (cap),
      .src_sw_o     (src_sw),
      .done_o       (cap_done_o)
   );

   ccap_bus_if #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
   ) u_bus (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr_i   (bus_addr_i),
      .bus_wr_i     (bus_wr_i),
      .bus_rd_i     (bus_rd_i),
      .bus_wdata_i  (bus_wdata_i),
      .bus_rdata_o  (bus_rdata_o),
      .cap_i        (cap),
      .src_sw_i     (src_sw),
      .en_o         (en),
      .sel_o        (sel),
      .sw_fire_o    (sw_fire),
      .commit_o     (commit),
      .commit_val_o (commit_val)
   );

   // R11: a commit that collides with a capture is dropped
   p_capture_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_fire && commit) |=> cap == $past(cnt_i));

endmodule

// File: tb/test_ctr_capture_unit.sv
`timescale 1ns/1ps
module test_ctr_capture_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] cnt = '0;
   logic        pin = 1'b0, cmp = 1'b0;
   logic [1:0]  addr = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        done;

   int checks = 0, failures = 0, done_cnt = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   ctr_capture_unit i_ctr_capture_unit (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .pin_evt_i(pin), .cmp_evt_i(cmp),
      .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .cap_done_o(done));

   always @(posedge clk) begin
      #1;
      if (rst_n && done) done_cnt++;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic read_cap(output logic [11:0] v);
      logic [7:0] lo, hi;
      bus_read(2'd1, lo);
      bus_read(2'd2, hi);
      v = {hi[3:0], lo};
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_line(input bit use_cmp);
      @(negedge clk);
      if (use_cmp) cmp = 1'b1; else pin = 1'b1;
      idle(8);
      if (use_cmp) cmp = 1'b0; else pin = 1'b0;
      idle(6);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 done", done, 0);
      bus_read(2'd0, d); chk("R1 ctrl", d, 8'h00);
      bus_read(2'd1, d); chk("R1 cap lo", d, 8'h00);
      bus_read(2'd2, d); chk("R1 hold", d, 8'h00);
   endtask

   task automatic t_sw_capture();
      logic [7:0] d; logic [11:0] v;
      cnt = 12'h5A3;
      bus_write(2'd0, 8'h80);
      chk("R2 done high", done, 1);
      @(negedge clk); chk("R2 done one cycle", done, 0);
      cnt = 12'h000;
      read_cap(v); chk("R2 cap value", v, 12'h5A3);
      bus_read(2'd0, d); chk("R3 sw flag", d, 8'h80);
   endtask

   task automatic t_hw_timing();
      logic [7:0] d; logic [11:0] v;
      bus_write(2'd0, 8'h01);
      bus_read(2'd0, d); chk("R3 flag kept", d, 8'h81);
      @(negedge clk); pin = 1'b1; cnt = 12'h100;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         chk($sformatf("R4 done at edge %0d", k), done, (k == 4) ? 1 : 0);
         cnt = 12'h100 * (k + 1) + 12'(k);
      end
      @(negedge clk); chk("R4 done drops", done, 0);
      pin = 1'b0; idle(6);
      read_cap(v); chk("R4 captured value", v, 12'h403);
      bus_read(2'd0, d); chk("R3 hw flag", d, 8'h01);
   endtask

   task automatic t_edges();
      int c0; logic [11:0] v;
      c0 = done_cnt; cnt = 12'h111;
      @(negedge clk); pin = 1'b1;
      idle(12);
      cnt = 12'h222;
      idle(12);
      chk("R5 level held", done_cnt - c0, 1);
      pin = 1'b0; idle(12);
      chk("R5 falling edge", done_cnt - c0, 1);
      read_cap(v); chk("R5 value", v, 12'h111);
   endtask

   task automatic t_enable();
      int c0; logic [11:0] v;
      bus_write(2'd0, 8'h00);
      c0 = done_cnt; cnt = 12'h333;
      pulse_line(0);
      chk("R7 no capture when disabled", done_cnt - c0, 0);
      read_cap(v); chk("R7 cap kept", v, 12'h111);
      cnt = 12'h7E7;
      bus_write(2'd0, 8'h80);
      cnt = 12'h000;
      read_cap(v); chk("R2 sw while disabled", v, 12'h7E7);
   endtask

   task automatic t_cmp();
      int c0; logic [11:0] v;
      bus_write(2'd0, 8'h03);
      idle(4);
      c0 = done_cnt; cnt = 12'h444;
      pulse_line(0);
      chk("R6 pin ignored", done_cnt - c0, 0);
      cnt = 12'h9C4;
      pulse_line(1);
      chk("R6 comparator captures", done_cnt - c0, 1);
      read_cap(v); chk("R6 value", v, 12'h9C4);
      bus_write(2'd0, 8'h01);
      idle(4);
   endtask

   task automatic t_collide();
      int c0; logic [7:0] d; logic [11:0] v;
      c0 = done_cnt; cnt = 12'h3C3;
      @(negedge clk); pin = 1'b1;
      idle(3);
      addr = 2'd0; wdata = 8'h81; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
      chk("R8 done", done, 1);
      @(negedge clk); chk("R8 single pulse", done, 0);
      pin = 1'b0; idle(8);
      chk("R8 one capture", done_cnt - c0, 1);
      bus_read(2'd0, d); chk("R8 flag software", d, 8'h81);
      read_cap(v); chk("R8 value", v, 12'h3C3);
   endtask

   task automatic t_atomic();
      logic [7:0] d; logic [11:0] v;
      cnt = 12'hABC; bus_write(2'd0, 8'h81);
      bus_read(2'd1, d); chk("R9 low byte", d, 8'hBC);
      cnt = 12'h123; bus_write(2'd0, 8'h81);
      bus_read(2'd2, d); chk("R9 frozen high", d, 8'h0A);
      read_cap(v); chk("R9 new value", v, 12'h123);
   endtask

   task automatic t_write();
      logic [7:0] d; logic [11:0] v;
      bus_write(2'd2, 8'h06);
      bus_read(2'd2, d); chk("R10 hold loaded", d, 8'h06);
      bus_read(2'd1, d); chk("R10 cap unchanged", d, 8'h23);
      bus_write(2'd2, 8'h06);
      bus_write(2'd1, 8'h5D);
      read_cap(v); chk("R10 commit", v, 12'h65D);
   endtask

   task automatic t_prio();
      int c0; logic [11:0] v;
      bus_write(2'd2, 8'h0F);
      c0 = done_cnt; cnt = 12'h2B4;
      @(negedge clk); pin = 1'b1;
      idle(3);
      addr = 2'd1; wdata = 8'h77; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
      pin = 1'b0; idle(8);
      chk("R11 capture happened", done_cnt - c0, 1);
      read_cap(v); chk("R11 capture wins", v, 12'h2B4);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #200000;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_sw_capture();
      t_hw_timing();
      t_edges();
      t_enable();
      t_cmp();
      t_collide();
      t_atomic();
      t_write();
      t_prio();
      idle(4);
      report();
   end

endmodule